// File: doc/BRIEF.md
# DMA Descriptor Reference Cache

This block batches the traffic between a DMA engine and the host-memory queues that hold descriptor references. On the receive side it keeps a small local stock of free-buffer references for the engine to consume. When that stock is empty, it fetches new references from the host in a single burst read. On the transmit side it collects the references of completed descriptors. Once a full batch of six has been gathered, it writes them back to the host free queue in a single burst.

The block drives one bus-master port. A request names a direction, a burst length and a priority flag, and is held until the bus grants it. Read data arrives as beats, and the host side can end a refill early with a last-beat marker. Write data is handed out one beat at a time under a ready handshake. An enable input chooses between batched write-back and write-back of each reference on its own.

Top module: `desc_ref_cache`

## Requirements
- R1: While reset is asserted and right after it, `bus_req_o`, `refill_pend_o` and `flush_pend_o` are low, both counts read 0 and `push_ready_o` is high.
- R2: When the stock holds no reference and no other transfer is underway, the block raises a refill request with `bus_dir_o`=0 (read), `bus_len_o`=6 and `bus_prio_o`=1. The request and its fields stay stable until `bus_gnt_i`, and `refill_pend_o` is high from the request until the refill ends.
- R3: A refill ends on its sixth accepted read beat, or earlier on a beat that carries `bus_rlast_i`=1. Every beat that is not consumed by a pop at once is added to the stock.
- R4: A pop asserted while the stock is empty and a read beat is arriving is served in that same cycle. `pop_valid_o` is 1 and `pop_ref_o` equals the arriving beat.
- R5: Popped references leave in the order in which the read beats delivered them, across refills.
- R6: With `cache_en_i`=1, a write-back is requested only when six references are held. It has `bus_dir_o`=1 (write), `bus_len_o`=6 and `bus_prio_o`=1.
- R7: With `cache_en_i`=0, every held reference is written back in its own transaction, with `bus_len_o`=1 and `bus_prio_o`=0.
- R8: `push_ready_o` is low while write-back data is moving and while six references are held. A push offered while it is low is not taken.
- R9: Write-back beats carry the references in the order in which they were pushed.
- R10: When a write-back and a refill are both needed at the same moment, the write-back is requested first.
- R11: `stock_cnt_o` and `batch_cnt_o` report the number of references held on each side, from 0 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cache_en_i | input | 1 | 1: write back in batches of six; 0: one reference per write |
| bus_req_o | output | 1 | Bus request, held until granted |
| bus_gnt_i | input | 1 | Grant for the pending request |
| bus_dir_o | output | 1 | 0 read (refill), 1 write (write-back) |
| bus_len_o | output | 3 | Burst length in references |
| bus_prio_o | output | 1 | Top-priority request flag |
| bus_rvalid_i | input | 1 | Read beat valid |
| bus_rdata_i | input | 32 | Read beat reference |
| bus_rlast_i | input | 1 | Read beat is the last one the host has |
| bus_wvalid_o | output | 1 | Write beat valid |
| bus_wdata_o | output | 32 | Write beat reference |
| bus_wready_i | input | 1 | Write beat accepted |
| pop_i | input | 1 | Consumer takes a free reference |
| pop_valid_o | output | 1 | A free reference is available |
| pop_ref_o | output | 32 | Free reference on offer |
| push_i | input | 1 | Producer returns a reference |
| push_ref_i | input | 32 | Returned reference |
| push_ready_o | output | 1 | Return accepted this cycle |
| stock_cnt_o | output | 3 | References in the receive stock |
| batch_cnt_o | output | 3 | References in the write-back batch |
| refill_pend_o | output | 1 | Refill requested or in progress |
| flush_pend_o | output | 1 | Write-back requested or in progress |

## Verification
A wrong pointer or count in either store appears at the ports within one cycle. It shows as a count that differs from the count of references accepted minus those released. It also shows as a popped or written-back reference that breaks arrival order. A broken bypass path makes `pop_valid_o` stay low in the very cycle a beat lands on an empty stock. A wrong mode or priority latch shows at the grant, where the direction, length and priority flag must agree with the counts the bench has tracked.

// File: rtl/desc_ref_cache_pkg.sv
`timescale 1ns/1ps
package desc_ref_cache_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_REQ, SEQ_RD, SEQ_WR} seq_state_e;
  localparam logic DIR_READ  = 1'b0;
  localparam logic DIR_WRITE = 1'b1;
endpackage

// File: rtl/ref_fifo.sv
`timescale 1ns/1ps
module ref_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 6,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     dout_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout_o = mem_q[rd_ptr_q];
  assign cnt_o  = cnt_q;

  // R11: the count stays within 0..DEPTH
  p_no_overflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> (cnt_q != CNT_W'(DEPTH)));
  p_no_underflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0));
endmodule

// File: rtl/bus_seq.sv
`timescale 1ns/1ps
module bus_seq
  import desc_ref_cache_pkg::*;
#(
  parameter int BATCH = 6,
  parameter int CNT_W = $clog2(BATCH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             refill_need_i,
  input  logic             flush_need_i,
  input  logic             flush_full_i,
  input  logic             gnt_i,
  input  logic             rvalid_i,
  input  logic             rlast_i,
  input  logic             wready_i,
  output logic             req_o,
  output logic             dir_o,
  output logic [CNT_W-1:0] len_o,
  output logic             prio_o,
  output logic             rd_act_o,
  output logic             wr_act_o,
  output logic             refill_pend_o,
  output logic             flush_pend_o
);
  seq_state_e       state_q, state_d;
  logic             dir_q, dir_d, prio_q, prio_d;
  logic [CNT_W-1:0] len_q, len_d, beat_q, beat_d;

  always_comb begin
    state_d = state_q;
    dir_d   = dir_q;
    len_d   = len_q;
    prio_d  = prio_q;
    beat_d  = beat_q;
    unique case (state_q)
      SEQ_IDLE: begin
        // write-back wins over refill
        if (flush_need_i) begin
          state_d = SEQ_REQ;
          dir_d   = DIR_WRITE;
          len_d   = flush_full_i ? CNT_W'(BATCH) : CNT_W'(1);
          prio_d  = flush_full_i;
        end else if (refill_need_i) begin
          state_d = SEQ_REQ;
          dir_d   = DIR_READ;
          len_d   = CNT_W'(BATCH);
          prio_d  = 1'b1;
        end
      end
      SEQ_REQ: begin
        beat_d = '0;
        if (gnt_i) state_d = (dir_q == DIR_WRITE) ? SEQ_WR : SEQ_RD;
      end
      SEQ_RD: begin
        if (rvalid_i) begin
          if (rlast_i || beat_q == CNT_W'(BATCH - 1)) state_d = SEQ_IDLE;
          else beat_d = beat_q + CNT_W'(1);
        end
      end
      SEQ_WR: begin
        if (wready_i) begin
          if (beat_q == len_q - CNT_W'(1)) state_d = SEQ_IDLE;
          else beat_d = beat_q + CNT_W'(1);
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      dir_q   <= DIR_READ;
      len_q   <= '0;
      prio_q  <= 1'b0;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
      len_q   <= len_d;
      prio_q  <= prio_d;
      beat_q  <= beat_d;
    end
  end

  assign req_o         = (state_q == SEQ_REQ);
  assign dir_o         = dir_q;
  assign len_o         = len_q;
  assign prio_o        = prio_q;
  assign rd_act_o      = (state_q == SEQ_RD);
  assign wr_act_o      = (state_q == SEQ_WR);
  assign refill_pend_o = (req_o && dir_q == DIR_READ) || rd_act_o;
  assign flush_pend_o  = (req_o && dir_q == DIR_WRITE) || wr_act_o;

  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i) |=> (req_o && $stable(dir_o) && $stable(len_o) && $stable(prio_o)));
  p_flush_first_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_IDLE && flush_need_i) |=> (req_o && dir_o == DIR_WRITE));
  p_rd_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_act_o |-> (beat_q < CNT_W'(BATCH)));
endmodule

// File: rtl/rx_stock.sv
`timescale 1ns/1ps
module rx_stock #(
  parameter int W     = 32,
  parameter int BATCH = 6,
  parameter int CNT_W = $clog2(BATCH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_valid_i,
  input  logic [W-1:0]     beat_i,
  input  logic             pop_i,
  output logic             pop_valid_o,
  output logic [W-1:0]     pop_ref_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             refill_need_o
);
  logic             empty, bypass, f_push, f_pop;
  logic [W-1:0]     head;
  logic [CNT_W-1:0] cnt;

  assign empty  = (cnt == '0);
  assign bypass = empty && beat_valid_i && pop_i;
  assign f_push = beat_valid_i && !bypass;
  assign f_pop  = pop_i && !empty;

  ref_fifo #(.W(W), .DEPTH(BATCH), .CNT_W(CNT_W)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (f_push),
    .din_i  (beat_i),
    .pop_i  (f_pop),
    .dout_o (head),
    .cnt_o  (cnt)
  );

  assign pop_valid_o   = !empty || beat_valid_i;
  assign pop_ref_o     = empty ? beat_i : head;
  assign cnt_o         = cnt;
  assign refill_need_o = empty;

  p_bypass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty && beat_valid_i && pop_i) |=> (cnt == '0));
endmodule

// File: rtl/tx_batch.sv
`timescale 1ns/1ps
module tx_batch #(
  parameter int W     = 32,
  parameter int BATCH = 6,
  parameter int CNT_W = $clog2(BATCH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             push_i,
  input  logic [W-1:0]     push_ref_i,
  output logic             push_ready_o,
  input  logic             wr_act_i,
  input  logic             drain_i,
  output logic [W-1:0]     wdata_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flush_need_o,
  output logic             flush_full_o
);
  logic [CNT_W-1:0] cnt;
  logic             full, take;

  assign full         = (cnt == CNT_W'(BATCH));
  assign push_ready_o = !wr_act_i && !full;
  assign take         = push_i && push_ready_o;

  ref_fifo #(.W(W), .DEPTH(BATCH), .CNT_W(CNT_W)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (take),
    .din_i  (push_ref_i),
    .pop_i  (drain_i),
    .dout_o (wdata_o),
    .cnt_o  (cnt)
  );

  assign cnt_o        = cnt;
  assign flush_need_o = en_i ? full : (cnt != '0);
  assign flush_full_o = en_i && full;

  // R8: no beat leaves an empty batch, no push lands during a burst
  p_drain_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_act_i && !drain_i) |=> $stable(cnt) || !wr_act_i);
endmodule

// File: rtl/desc_ref_cache.sv
`timescale 1ns/1ps
module desc_ref_cache
  import desc_ref_cache_pkg::*;
#(
  parameter int REF_W = 32,
  parameter int BATCH = 6,
  parameter int CNT_W = $clog2(BATCH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cache_en_i,
  output logic             bus_req_o,
  input  logic             bus_gnt_i,
  output logic             bus_dir_o,
  output logic [CNT_W-1:0] bus_len_o,
  output logic             bus_prio_o,
  input  logic             bus_rvalid_i,
  input  logic [REF_W-1:0] bus_rdata_i,
  input  logic             bus_rlast_i,
  output logic             bus_wvalid_o,
  output logic [REF_W-1:0] bus_wdata_o,
  input  logic             bus_wready_i,
  input  logic             pop_i,
  output logic             pop_valid_o,
  output logic [REF_W-1:0] pop_ref_o,
  input  logic             push_i,
  input  logic [REF_W-1:0] push_ref_i,
  output logic             push_ready_o,
  output logic [CNT_W-1:0] stock_cnt_o,
  output logic [CNT_W-1:0] batch_cnt_o,
  output logic             refill_pend_o,
  output logic             flush_pend_o
);
  logic rd_act, wr_act, refill_need, flush_need, flush_full;

  bus_seq #(.BATCH(BATCH), .CNT_W(CNT_W)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .refill_need_i (refill_need),
    .flush_need_i  (flush_need),
    .flush_full_i  (flush_full),
    .gnt_i         (bus_gnt_i),
    .rvalid_i      (bus_rvalid_i),
    .rlast_i       (bus_rlast_i),
    .wready_i      (bus_wready_i),
    .req_o         (bus_req_o),
    .dir_o         (bus_dir_o),
    .len_o         (bus_len_o),
    .prio_o        (bus_prio_o),
    .rd_act_o      (rd_act),
    .wr_act_o      (wr_act),
    .refill_pend_o (refill_pend_o),
    .flush_pend_o  (flush_pend_o)
  );

  rx_stock #(.W(REF_W), .BATCH(BATCH), .CNT_W(CNT_W)) u_rx (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .beat_valid_i  (rd_act && bus_rvalid_i),
    .beat_i        (bus_rdata_i),
    .pop_i         (pop_i),
    .pop_valid_o   (pop_valid_o),
    .pop_ref_o     (pop_ref_o),
    .cnt_o         (stock_cnt_o),
    .refill_need_o (refill_need)
  );

  tx_batch #(.W(REF_W), .BATCH(BATCH), .CNT_W(CNT_W)) u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (cache_en_i),
    .push_i       (push_i),
    .push_ref_i   (push_ref_i),
    .push_ready_o (push_ready_o),
    .wr_act_i     (wr_act),
    .drain_i      (wr_act && bus_wready_i),
    .wdata_o      (bus_wdata_o),
    .cnt_o        (batch_cnt_o),
    .flush_need_o (flush_need),
    .flush_full_o (flush_full)
  );

  assign bus_wvalid_o = wr_act;

  p_full_batch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_dir_o && bus_prio_o) |-> (batch_cnt_o == CNT_W'(BATCH)));
  p_refill_empty_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(refill_pend_o) |-> (stock_cnt_o == '0));
  p_ready_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wvalid_o |-> !push_ready_o);
endmodule

// File: tb/desc_ref_cache_bench.sv
`timescale 1ns/1ps
module desc_ref_cache_bench;
  localparam int W = 32;
  localparam int B = 6;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cache_en = 1'b1;
  logic bus_req, bus_dir, bus_prio, bus_wvalid;
  logic [CW-1:0] bus_len, stock_cnt, batch_cnt;
  logic bus_gnt = 1'b0, bus_rvalid = 1'b0, bus_rlast = 1'b0, bus_wready = 1'b0;
  logic [W-1:0] bus_rdata = '0, bus_wdata, pop_ref, push_ref = '0;
  logic pop = 1'b0, pop_valid, push = 1'b0, push_ready, refill_pend, flush_pend;

  always #2.5 clk = ~clk;

  desc_ref_cache #(.REF_W(W), .BATCH(B)) u_desc_ref_cache (
    .clk_i(clk), .rst_ni(rst_n), .cache_en_i(cache_en),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_dir_o(bus_dir),
    .bus_len_o(bus_len), .bus_prio_o(bus_prio),
    .bus_rvalid_i(bus_rvalid), .bus_rdata_i(bus_rdata), .bus_rlast_i(bus_rlast),
    .bus_wvalid_o(bus_wvalid), .bus_wdata_o(bus_wdata), .bus_wready_i(bus_wready),
    .pop_i(pop), .pop_valid_o(pop_valid), .pop_ref_o(pop_ref),
    .push_i(push), .push_ref_i(push_ref), .push_ready_o(push_ready),
    .stock_cnt_o(stock_cnt), .batch_cnt_o(batch_cnt),
    .refill_pend_o(refill_pend), .flush_pend_o(flush_pend)
  );

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] sup [8192];
  logic [W-1:0] pushed [8192];
  int nsup = 0, npop = 0, npush = 0, nwr = 0;
  bit wb_busy = 0, stop = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] sup_id(input int i);
    return 32'h1000_0000 + W'(i);
  endfunction
  function automatic logic [W-1:0] push_id(input int i);
    return 32'h2000_0000 + W'(i);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wait_req();
    while (!bus_req) tick();
  endtask

  task automatic grant_check(input logic dir, input int len, input logic prio, input string req);
    check(bus_dir == dir, req, bus_dir, dir);
    check(bus_len == CW'(len), req, bus_len, len);
    check(bus_prio == prio, req, bus_prio, prio);
    bus_gnt = 1'b1;
    tick();
    bus_gnt = 1'b0;
  endtask

  // drive one read beat at the current negedge; pop result checked at +0.5
  task automatic beat(input bit last, input bit do_pop);
    bus_rvalid = 1'b1;
    bus_rdata  = sup_id(nsup);
    bus_rlast  = last;
    sup[nsup]  = sup_id(nsup);
    pop        = do_pop;
    #0.5;
    if (do_pop) begin
      check(pop_valid, "R4", pop_valid, 1);
      check(pop_ref == sup[npop], "R4", pop_ref, sup[npop]);
      npop++;
    end
    #0.5 nsup++;
    tick();
    bus_rvalid = 1'b0;
    bus_rlast  = 1'b0;
    pop        = 1'b0;
  endtask

  task automatic do_pop_chk();
    pop = 1'b1;
    #0.5;
    check(pop_valid, "R5", pop_valid, 1);
    check(pop_ref == sup[npop], "R5", pop_ref, sup[npop]);
    npop++;
  endtask

  task automatic do_push(input bit expect_ok, input string req);
    push     = 1'b1;
    push_ref = push_id(npush);
    #0.5;
    check(push_ready == expect_ok, req, push_ready, expect_ok);
    if (push_ready) begin
      pushed[npush] = push_id(npush);
      npush++;
    end
  endtask

  task automatic write_beats(input int n, input bit try_push);
    for (int k = 0; k < n; k++) begin
      bus_wready = 1'b1;
      if (try_push) begin
        push = 1'b1;
        push_ref = 32'hdead_beef;
      end
      #0.5;
      check(bus_wvalid, "R9", bus_wvalid, 1);
      check(bus_wdata == pushed[nwr], "R9", bus_wdata, pushed[nwr]);
      if (try_push) check(!push_ready, "R8", push_ready, 0);
      nwr++;
      tick();
    end
    bus_wready = 1'b0;
    push = 1'b0;
  endtask

  // random-phase processes
  task automatic host_loop();
    while (!stop) begin
      tick();
      bus_gnt = 1'b0;
      if (bus_req && $urandom_range(3) == 0) begin
        if (bus_dir == 1'b0) begin
          check(stock_cnt == 3'd0 && nsup == npop, "R2", stock_cnt, 0);
          grant_check(1'b0, B, 1'b1, "R2");
          begin
            int n = $urandom_range(1, B);
            for (int k = 0; k < n; k++) begin
              while ($urandom_range(2) == 0) begin
                bus_rvalid = 1'b0;
                tick();
              end
              bus_rvalid = 1'b1;
              bus_rdata  = sup_id(nsup);
              bus_rlast  = (k == n - 1);
              sup[nsup]  = sup_id(nsup);
              #1 nsup++;
              tick();
            end
            bus_rvalid = 1'b0;
            bus_rlast  = 1'b0;
          end
        end else begin
          check(npush - nwr == B, "R6", npush - nwr, B);
          grant_check(1'b1, B, 1'b1, "R6");
          wb_busy = 1;
          begin
            int got = 0;
            while (got < B) begin
              bus_wready = 1'($urandom_range(1));
              #0.5;
              check(bus_wvalid, "R9", bus_wvalid, 1);
              if (bus_wready) begin
                check(bus_wdata == pushed[nwr], "R9", bus_wdata, pushed[nwr]);
                nwr++;
                got++;
              end
              tick();
            end
          end
          wb_busy = 0;
          bus_wready = 1'b0;
        end
      end
    end
  endtask

  task automatic cons_loop();
    repeat (3000) begin
      tick();
      pop = 1'($urandom_range(2) != 0);
      #0.25;
      check(stock_cnt == CW'(nsup - npop), "R11", stock_cnt, nsup - npop);
      #0.25;
      if (bus_rvalid && nsup == npop) check(pop_valid, "R4", pop_valid, 1);
      if (pop_valid && nsup == npop && !bus_rvalid) check(0, "R5", pop_valid, 0);
      if (pop && pop_valid) begin
        check(pop_ref == sup[npop], "R5", pop_ref, sup[npop]);
        npop++;
      end
    end
    pop = 1'b0;
  endtask

  task automatic prod_loop();
    repeat (3000) begin
      tick();
      push = 1'($urandom_range(3) == 0);
      push_ref = push_id(npush);
      #0.25;
      check(batch_cnt == CW'(npush - nwr), "R11", batch_cnt, npush - nwr);
      if (wb_busy) check(!push_ready, "R8", push_ready, 0);
      #0.25;
      if (push && push_ready) begin
        pushed[npush] = push_id(npush);
        npush++;
      end
    end
    push = 1'b0;
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    // R1: reset state
    #12;
    check(!bus_req && !refill_pend && !flush_pend, "R1", {bus_req, refill_pend, flush_pend}, 0);
    check(stock_cnt == 0 && batch_cnt == 0, "R1", {stock_cnt, batch_cnt}, 0);
    check(push_ready, "R1", push_ready, 1);
    tick();
    rst_n = 1'b1;
    #0.5 check(!bus_req, "R1", bus_req, 0);

    // R2/R3: refill request, early end by last flag
    wait_req();
    check(refill_pend && !flush_pend, "R2", {refill_pend, flush_pend}, 2'b10);
    grant_check(1'b0, B, 1'b1, "R2");
    beat(0, 0); beat(0, 0); beat(1, 0);
    check(stock_cnt == 3, "R3", stock_cnt, 3);
    check(!refill_pend && !bus_req, "R3", {refill_pend, bus_req}, 0);

    // R6: five returned refs do not trigger write-back
    for (int i = 0; i < 5; i++) begin do_push(1, "R8"); tick(); end
    push = 1'b0;
    tick();
    check(batch_cnt == 5, "R11", batch_cnt, 5);
    check(!bus_req, "R6", bus_req, 0);
    // drain stock while the sixth push lands: both needs appear together
    do_pop_chk(); tick();
    do_pop_chk(); tick();
    do_pop_chk(); do_push(1, "R8"); tick();
    pop = 1'b0; push = 1'b0;
    wait_req();
    check(bus_dir == 1'b1, "R10", bus_dir, 1);
    check(flush_pend && !refill_pend, "R10", {flush_pend, refill_pend}, 2'b10);
    check(!push_ready, "R8", push_ready, 0);
    grant_check(1'b1, B, 1'b1, "R6");
    write_beats(B, 1);
    check(batch_cnt == 0, "R11", batch_cnt, 0);

    // R2/R4/R3: refill after flush; bypass pop; end by count
    wait_req();
    grant_check(1'b0, B, 1'b1, "R2");
    beat(0, 1);
    for (int i = 0; i < B - 1; i++) beat(0, 0);
    check(stock_cnt == 5, "R3", stock_cnt, 5);
    check(!refill_pend, "R3", refill_pend, 0);

    // R7: uncached single write-backs
    cache_en = 1'b0;
    do_push(1, "R8"); tick();
    do_push(1, "R8"); tick();
    push = 1'b0;
    for (int i = 0; i < 2; i++) begin
      wait_req();
      grant_check(1'b1, 1, 1'b0, "R7");
      write_beats(1, 0);
    end
    tick();
    check(batch_cnt == 0, "R7", batch_cnt, 0);
    cache_en = 1'b1;

    // random phase, batched mode
    fork
      begin
        fork
          cons_loop();
          prod_loop();
        join
        stop = 1;
      end
      host_loop();
    join
    tick();
    check(nwr > 12 && npop > 12, "R9", {nwr[15:0], npop[15:0]}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule